// File: doc/BRIEF.md
# Masked Pin Change Interrupt Detector

This block watches a group of eight input pins and folds any toggle on them into one shared interrupt. Each pin first passes through a two-stage synchronizer. A change in either direction is found by comparing the synchronized value with the value one cycle earlier. Only pins whose bit is set in a mask register take part. Any such change sets one pending flag.

An interrupt request goes out while the flag is set, the group enable bit is set and the processor's global interrupt enable input is high. All eight pins share that one request line. The flag clears when the processor acknowledges the interrupt, or when software writes a one to the flag bit. A fresh change that lands in the same cycle as a clear takes priority, so the event is not lost.

Software reaches the block through a simple write strobe and a combinational read port, both addressed by a two-bit register select.

Top module: `pin_group_irq`

## Requirements
- R1: After reset the mask register, the enable bit and the pending flag are all 0, every register reads 0x00 and `irqReq` is 0.
- R2: A change on an unmasked pin sets the flag. The flag reads 1 on the third rising clock edge after the pin change, and it still reads 0 after the second.
- R3: A falling transition sets the flag in the same way as a rising one.
- R4: Toggles on pins whose mask bit is 0 never set the flag.
- R5: Writing the mask register does not set the flag by itself, even when a pin held high is unmasked. Only transitions that happen while the pin is unmasked count.
- R6: `irqReq` is 1 exactly when the flag, the group enable bit and `globalIrqEn` are all 1.
- R7: A one-cycle pulse on `irqAck` clears the flag at the next rising edge.
- R8: Writing select 2 with data bit 0 set clears the flag. Writing it with bit 0 at 0 leaves the flag unchanged.
- R9: If a qualifying pin change reaches the flag in the same cycle as a clear, whether from the acknowledge or from a write-one, the flag stays 1.
- R10: In the control register (select 1) and the flag register (select 2), bits 7:1 always read 0, even after ones are written to them.
- R11: The register select values are: 0 = mask (8 bits, bit i controls pin i), 1 = control (bit 0 = group enable), 2 = flag (bit 0 = pending). Select 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | Monitored pins, asynchronous to clk |
| globalIrqEn | input | 1 | Processor-wide interrupt enable |
| irqAck | input | 1 | Acknowledge of the shared interrupt; clears the flag |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select for writes |
| wrData | input | 8 | Write data |
| rdSel | input | 2 | Register select for reads |
| rdData | output | 8 | Read data (combinational) |
| irqReq | output | 1 | Shared interrupt request |

## Verification
The flag has one set path and two clear paths, and a set and a clear can fall in the same cycle. To provoke this, the bench first sets the flag. It then toggles an unmasked pin and times an acknowledge pulse, and in a second run a write-one to the flag, so that the clear lands on the rising edge where the synchronized change reaches the flag. The result is correct only if the flag still reads 1 afterwards. Separate runs clear the flag with no change pending, to show that each clear path works on its own.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic maskWr;
    logic enWr;
    logic flagClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/pcirq_ctrl.sv
module pcirq_ctrl
  import pcirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              irqAck,
  output ctrlStrobe_t       strobe
);

  regSel_e sel;
  logic    w1cHit;

  always_comb begin
    sel    = regSel_e'(wrSel);
    w1cHit = wrEn && (sel == SEL_FLAG) && wrData[0];
    strobe.maskWr  = wrEn && (sel == SEL_MASK);
    strobe.enWr    = wrEn && (sel == SEL_CTRL);
    strobe.flagClr = irqAck || w1cHit;
  end

endmodule

// File: rtl/pcirq_datapath.sv
module pcirq_datapath
  import pcirq_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  ctrlStrobe_t          strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 globalIrqEn,
  input  logic [SEL_W-1:0]     rdSel,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqReq,
  output logic [PIN_COUNT-1:0] maskQ,
  output logic                 enQ,
  output logic                 flagQ,
  output logic [PIN_COUNT-1:0] rawChange
);

  logic [PIN_COUNT-1:0] pinSync;
  logic [PIN_COUNT-1:0] pinPrev;
  logic                 hitAny;

  pcirq_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  assign rawChange = pinSync ^ pinPrev;
  assign hitAny    = |(rawChange & maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      enQ   <= 1'b0;
      flagQ <= 1'b0;
    end else begin
      if (strobe.maskWr) maskQ <= wrData[PIN_COUNT-1:0];
      if (strobe.enWr)   enQ   <= wrData[0];
      flagQ <= hitAny || (flagQ && !strobe.flagClr);
    end
  end

  assign irqReq = flagQ && enQ && globalIrqEn;

  always_comb begin
    rdData = '0;
    case (regSel_e'(rdSel))
      SEL_MASK: rdData = DATA_W'(maskQ);
      SEL_CTRL: rdData = DATA_W'(enQ);
      SEL_FLAG: rdData = DATA_W'(flagQ);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/pin_group_irq.sv
module pin_group_irq
  import pcirq_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 globalIrqEn,
  input  logic                 irqAck,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [1:0]           rdSel,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqReq
);

  ctrlStrobe_t          strobe;
  logic [PIN_COUNT-1:0] maskQ;
  logic                 enQ;
  logic                 flagQ;
  logic [PIN_COUNT-1:0] rawChange;

  pcirq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .irqAck (irqAck),
    .strobe (strobe)
  );

  pcirq_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pinIn       (pinIn),
    .strobe      (strobe),
    .wrData      (wrData),
    .globalIrqEn (globalIrqEn),
    .rdSel       (rdSel),
    .rdData      (rdData),
    .irqReq      (irqReq),
    .maskQ       (maskQ),
    .enQ         (enQ),
    .flagQ       (flagQ),
    .rawChange   (rawChange)
  );

endmodule

// File: rtl/pin_group_irq_checker.sv
module pin_group_irq_checker #(
  parameter int PIN_COUNT = 8,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 irqReq,
  input logic                 globalIrqEn,
  input logic                 irqAck,
  input logic                 wrEn,
  input logic [1:0]           wrSel,
  input logic [DATA_W-1:0]    wrData,
  input logic [1:0]           rdSel,
  input logic [DATA_W-1:0]    rdData,
  input logic [PIN_COUNT-1:0] maskQ,
  input logic                 enQ,
  input logic                 flagQ,
  input logic [PIN_COUNT-1:0] rawChange
);

  logic hit;
  logic w1c;
  assign hit = |(rawChange & maskQ);
  assign w1c = wrEn && (wrSel == 2'd2) && wrData[0];

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !hit && !w1c && !irqAck) |=> !flagQ); // R4

  AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> flagQ); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !hit) |=> !flagQ); // R7

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (w1c && !hit) |=> !flagQ); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (globalIrqEn && enQ && flagQ)); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == 2'd1 || rdSel == 2'd2) |-> (rdData[DATA_W-1:1] == '0)); // R10

endmodule

bind pin_group_irq pin_group_irq_checker #(
  .PIN_COUNT (PIN_COUNT),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .irqReq      (irqReq),
  .globalIrqEn (globalIrqEn),
  .irqAck      (irqAck),
  .wrEn        (wrEn),
  .wrSel       (wrSel),
  .wrData      (wrData),
  .rdSel       (rdSel),
  .rdData      (rdData),
  .maskQ       (maskQ),
  .enQ         (enQ),
  .flagQ       (flagQ),
  .rawChange   (rawChange)
);

// File: tb/pin_group_irq_tb.sv
module pin_group_irq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0;
  logic       globalIrqEn = 1'b0;
  logic       irqAck = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdSel = '0;
  logic [7:0] rdData;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_group_irq u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIrqEn(globalIrqEn),
    .irqAck(irqAck), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .irqReq(irqReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] data);
    rdSel = sel;
    #1;
    data = rdData;
  endtask

  task automatic togglePins(input logic [7:0] m);
    @(negedge clk);
    pinIn = pinIn ^ m;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseAck();
    @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    readReg(2'd0, v); check("R1 mask", v, 8'h00);
    readReg(2'd1, v); check("R1 ctrl", v, 8'h00);
    readReg(2'd2, v); check("R1 flag", v, 8'h00);
    check("R1 irqReq", {7'b0, irqReq}, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    writeReg(2'd0, 8'hA5); readReg(2'd0, v); check("R11 mask rw", v, 8'hA5);
    writeReg(2'd1, 8'hFF); readReg(2'd1, v); check("R10 ctrl upper", v, 8'h01);
    writeReg(2'd2, 8'hFE); readReg(2'd2, v); check("R10 flag upper", v, 8'h00);
    writeReg(2'd3, 8'hFF); readReg(2'd3, v); check("R11 sel3", v, 8'h00);
    readReg(2'd0, v); check("R11 sel3 no side effect", v, 8'hA5);
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'h00);
  endtask

  task automatic t_rise();
    logic [7:0] v;
    writeReg(2'd0, 8'h01);
    writeReg(2'd1, 8'h01);
    globalIrqEn = 1'b1;
    @(negedge clk);
    pinIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    readReg(2'd2, v); check("R2 latency not early", v, 8'h00);
    @(negedge clk);
    readReg(2'd2, v); check("R2 rise sets flag", v, 8'h01);
    check("R6 irq all set", {7'b0, irqReq}, 8'h01);
    pulseAck();
    readReg(2'd2, v); check("R7 ack clears", v, 8'h00);
    check("R7 irq drops", {7'b0, irqReq}, 8'h00);
  endtask

  task automatic t_fall();
    logic [7:0] v;
    togglePins(8'h01);
    readReg(2'd2, v); check("R3 fall sets flag", v, 8'h01);
    writeReg(2'd2, 8'h00);
    readReg(2'd2, v); check("R8 write zero keeps", v, 8'h01);
    writeReg(2'd2, 8'h01);
    readReg(2'd2, v); check("R8 write one clears", v, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] v;
    togglePins(8'h80);
    repeat (3) @(negedge clk);
    readReg(2'd2, v); check("R4 masked pin ignored", v, 8'h00);
    togglePins(8'h7E);
    togglePins(8'h7E);
    readReg(2'd2, v); check("R4 masked group ignored", v, 8'h00);
  endtask

  task automatic t_maskChange();
    logic [7:0] v;
    writeReg(2'd0, 8'hFF);
    repeat (4) @(negedge clk);
    readReg(2'd2, v); check("R5 unmask alone", v, 8'h00);
    togglePins(8'h80);
    readReg(2'd2, v); check("R2 pin7 after unmask", v, 8'h01);
    pulseAck();
  endtask

  task automatic t_gate();
    togglePins(8'h04);
    globalIrqEn = 1'b0;
    #1 check("R6 global off", {7'b0, irqReq}, 8'h00);
    globalIrqEn = 1'b1;
    writeReg(2'd1, 8'h00);
    #1 check("R6 group off", {7'b0, irqReq}, 8'h00);
    writeReg(2'd1, 8'h01);
    #1 check("R6 both on", {7'b0, irqReq}, 8'h01);
    pulseAck();
  endtask

  task automatic t_coincide();
    logic [7:0] v;
    togglePins(8'h02);
    @(negedge clk);
    pinIn[1] = ~pinIn[1];
    repeat (2) @(negedge clk);
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
    readReg(2'd2, v); check("R9 ack vs change", v, 8'h01);
    @(negedge clk);
    pinIn[1] = ~pinIn[1];
    repeat (2) @(negedge clk);
    wrEn = 1'b1; wrSel = 2'd2; wrData = 8'h01;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    readReg(2'd2, v); check("R9 w1c vs change", v, 8'h01);
    pulseAck();
    readReg(2'd2, v); check("R7 final clear", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_masked();
    t_maskChange();
    t_gate();
    t_coincide();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule